// File: doc/BRIEF.md
# On-the-Fly 64-bit Round Key Updater

This block produces the sequence of 64-bit round keys for a lightweight substitution-permutation block cipher, one key per step, without storing an expanded schedule. A master key is loaded into a key register; each step pulse replaces the held key with its successor and advances a 5-bit round counter. The successor is formed by a byte-rotating Feistel swap of the two 32-bit halves. The round counter is folded into a 5-bit field, and four nibbles pass through the cipher's 4-bit involutive S-box.

The successor of the held key is also driven combinationally on a preview port. A cipher datapath can therefore use the next key in the same cycle it issues the step. The schedule uses exactly four S-box instances.

Top module: `key_sched_top`

## Requirements
- R1: After reset, keyOut is all zeros and roundOut is 1.
- R2: A loadKey pulse makes keyOut equal masterKey and roundOut equal 1 on the next clock edge.
- R3: The update splits the key into hi = bits 63:32 and lo = bits 31:0. It rotates each half left by 8 bits with wraparound. The new bits 63:32 are rotated lo, and the new bits 31:0 are rotated hi XOR rotated lo.
- R4: The current roundOut value (5 bits) is XORed into bits 44:40 of the swapped key.
- R5: Each of the four nibbles at bits 23:8 of the swapped key is replaced through the S-box. For inputs 0..F the S-box gives 7,4,A,9,1,F,B,0,C,3,2,6,8,E,D,5. All other bits pass unchanged.
- R6: A stepKey pulse (without loadKey) sets keyOut to the keyPreview value of that cycle. It also increments roundOut by one, wrapping from 31 to 0.
- R7: loadKey takes priority over stepKey in the same cycle.
- R8: With neither loadKey nor stepKey, keyOut and roundOut hold their values.
- R9: keyPreview is always the update (R3-R5 applied) of the current keyOut using the current roundOut.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadKey | input | 1 | Load masterKey and restart the round count |
| masterKey | input | 64 | Master key value |
| stepKey | input | 1 | Advance to the next round key |
| keyOut | output | 64 | Current round key |
| roundOut | output | 5 | Round counter used by the next update |
| keyPreview | output | 64 | Combinational successor of keyOut |

## Verification
On every cycle, the assertions check the register transfers: load restarting the count, a step adopting the previewed key and bumping the counter, and idle cycles holding state. Whether the preview itself is correct is a matter of bit placement: rotation wraparound, where the counter lands, and which nibbles are substituted. Only the bench's scenarios can show this. They compare against known vectors and an independent model, including a case where the counter cancels a rotated bit and a full counter wrap.

// File: rtl/key_sched_pkg.sv
package key_sched_pkg;
  localparam int KeyW   = 64;
  localparam int HalfW  = KeyW / 2;
  localparam int RotW   = 8;
  localparam int RoundW = 5;
  localparam int RcLsb  = 40;
  localparam int SubLsb = 8;
  localparam int NibW   = 4;
  localparam int SubCnt = 4;

  typedef struct packed {
    logic loadEn;
    logic stepEn;
  } keyStrobe_t;
endpackage

// File: rtl/key_nib_sbox.sv
module key_nib_sbox (
  input  logic [3:0] nibIn,
  output logic [3:0] nibOut
);
  always_comb begin
    case (nibIn)
      4'h0: nibOut = 4'h7;
      4'h1: nibOut = 4'h4;
      4'h2: nibOut = 4'hA;
      4'h3: nibOut = 4'h9;
      4'h4: nibOut = 4'h1;
      4'h5: nibOut = 4'hF;
      4'h6: nibOut = 4'hB;
      4'h7: nibOut = 4'h0;
      4'h8: nibOut = 4'hC;
      4'h9: nibOut = 4'h3;
      4'hA: nibOut = 4'h2;
      4'hB: nibOut = 4'h6;
      4'hC: nibOut = 4'h8;
      4'hD: nibOut = 4'hE;
      4'hE: nibOut = 4'hD;
      default: nibOut = 4'h5;
    endcase
  end
endmodule

// File: rtl/key_step_comb.sv
module key_step_comb
  import key_sched_pkg::*;
(
  input  logic [KeyW-1:0]   keyIn,
  input  logic [RoundW-1:0] roundIn,
  output logic [KeyW-1:0]   keyNext
);
  localparam int SubW = SubCnt * NibW;

  logic [HalfW-1:0] hiRot, loRot;
  logic [KeyW-1:0]  swapped, salted;
  logic [SubW-1:0]  subOut;

  // byte rotation of each half, wrapping
  assign hiRot = {keyIn[KeyW-1-RotW:HalfW], keyIn[KeyW-1 -: RotW]};
  assign loRot = {keyIn[HalfW-1-RotW:0], keyIn[HalfW-1 -: RotW]};
  assign swapped = {loRot, hiRot ^ loRot};

  always_comb begin
    salted = swapped;
    salted[RcLsb +: RoundW] = swapped[RcLsb +: RoundW] ^ roundIn;
  end

  for (genvar i = 0; i < SubCnt; i++) begin : g_sub
    key_nib_sbox u_sbox (
      .nibIn (salted[SubLsb + i*NibW +: NibW]),
      .nibOut(subOut[i*NibW +: NibW])
    );
  end

  always_comb begin
    keyNext = salted;
    keyNext[SubLsb +: SubW] = subOut;
  end
endmodule

// File: rtl/key_sched_ctrl.sv
module key_sched_ctrl
  import key_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadKey,
  input  logic              stepKey,
  output keyStrobe_t        strobe,
  output logic [RoundW-1:0] roundNum
);
  localparam logic [RoundW-1:0] FirstRound = RoundW'(1);

  always_comb begin
    strobe.loadEn = loadKey;
    strobe.stepEn = stepKey & ~loadKey;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               roundNum <= FirstRound;
    else if (strobe.loadEn)  roundNum <= FirstRound;
    else if (strobe.stepEn)  roundNum <= roundNum + RoundW'(1);
  end
endmodule

// File: rtl/key_sched_dp.sv
module key_sched_dp
  import key_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  keyStrobe_t        strobe,
  input  logic [KeyW-1:0]   masterKey,
  input  logic [RoundW-1:0] roundNum,
  output logic [KeyW-1:0]   keyReg,
  output logic [KeyW-1:0]   keyNext
);
  key_step_comb u_step (
    .keyIn  (keyReg),
    .roundIn(roundNum),
    .keyNext(keyNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN)              keyReg <= '0;
    else if (strobe.loadEn) keyReg <= masterKey;
    else if (strobe.stepEn) keyReg <= keyNext;
  end
endmodule

// File: rtl/key_sched_top.sv
module key_sched_top
  import key_sched_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadKey,
  input  logic [KeyW-1:0]   masterKey,
  input  logic              stepKey,
  output logic [KeyW-1:0]   keyOut,
  output logic [RoundW-1:0] roundOut,
  output logic [KeyW-1:0]   keyPreview
);
  keyStrobe_t strobe;

  key_sched_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadKey (loadKey),
    .stepKey (stepKey),
    .strobe  (strobe),
    .roundNum(roundOut)
  );

  key_sched_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .masterKey(masterKey),
    .roundNum (roundOut),
    .keyReg   (keyOut),
    .keyNext  (keyPreview)
  );
endmodule

// File: rtl/key_sched_chk.sv
module key_sched_chk
  import key_sched_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              loadKey,
  input logic [KeyW-1:0]   masterKey,
  input logic              stepKey,
  input logic [KeyW-1:0]   keyOut,
  input logic [RoundW-1:0] roundOut,
  input logic [KeyW-1:0]   keyPreview
);
  // R2
  load_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadKey |=> (keyOut == $past(masterKey)) && (roundOut == RoundW'(1)));

  // R6
  step_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepKey && !loadKey) |=> keyOut == $past(keyPreview));

  // R6
  step_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stepKey && !loadKey) |=> roundOut == $past(roundOut) + RoundW'(1));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stepKey && !loadKey) |=> $stable(keyOut) && $stable(roundOut));
endmodule

bind key_sched_top key_sched_chk u_chk (
  .clk(clk), .rstN(rstN), .loadKey(loadKey), .masterKey(masterKey),
  .stepKey(stepKey), .keyOut(keyOut), .roundOut(roundOut),
  .keyPreview(keyPreview)
);

// File: tb/key_sched_top_test.sv
module key_sched_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadKey = 1'b0;
  logic [63:0] masterKey = '0;
  logic        stepKey = 1'b0;
  logic [63:0] keyOut, keyPreview;
  logic [4:0]  roundOut;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  key_sched_top uut (
    .clk(clk), .rstN(rstN), .loadKey(loadKey), .masterKey(masterKey),
    .stepKey(stepKey), .keyOut(keyOut), .roundOut(roundOut),
    .keyPreview(keyPreview)
  );

  function automatic logic [3:0] sb(input logic [3:0] x);
    logic [63:0] tbl = 64'h5DE8623C0BF19A47;
    return tbl[x*4 +: 4];
  endfunction

  function automatic logic [63:0] model(input logic [63:0] k, input logic [4:0] r);
    logic [31:0] h, l;
    logic [63:0] s;
    h = {k[55:32], k[63:56]};
    l = {k[23:0], k[31:24]};
    s = {l, h ^ l};
    s[44:40] ^= r;
    for (int i = 0; i < 4; i++) s[8+4*i +: 4] = sb(s[8+4*i +: 4]);
    return s;
  endfunction

  task automatic chk64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk5(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle(input logic ld, input logic st, input logic [63:0] mk);
    @(negedge clk);
    loadKey = ld; stepKey = st; masterKey = mk;
    @(negedge clk);
    loadKey = 1'b0; stepKey = 1'b0;
  endtask

  task automatic testReset();
    chk64("R1 key", keyOut, 64'h0);
    chk5("R1 round", roundOut, 5'd1);
  endtask

  task automatic testZeroKey();
    cycle(1'b1, 1'b0, 64'h0);
    chk5("R2 round", roundOut, 5'd1);
    // R4 counter at 44:40, R5 S(0)=7 on 23:8
    chk64("R4 R5 preview zero", keyPreview, 64'h0000_0100_0077_7700);
    cycle(1'b0, 1'b1, 64'h0);
    chk64("R6 step zero", keyOut, 64'h0000_0100_0077_7700);
    chk5("R6 round 2", roundOut, 5'd2);
  endtask

  task automatic testCancel();
    cycle(1'b1, 1'b0, 64'h1);
    chk64("R2 key", keyOut, 64'h1);
    // R3 rotated bit lands on 40 and counter cancels it
    chk64("R3 R4 cancel", keyPreview, 64'h0000_0000_0077_7400);
  endtask

  task automatic testChain();
    logic [63:0] exp = 64'h0123_4567_89AB_CDEF;
    cycle(1'b1, 1'b0, exp);
    chk64("R2 load chain", keyOut, exp);
    for (int i = 1; i <= 12; i++) begin
      chk64("R9 preview", keyPreview, model(exp, 5'(i)));
      exp = model(exp, 5'(i));
      cycle(1'b0, 1'b1, 64'h0);
      chk64("R3 chain key", keyOut, exp);
    end
    chk5("R6 round 13", roundOut, 5'd13);
  endtask

  task automatic testIdle();
    logic [63:0] k = keyOut;
    logic [4:0]  r = roundOut;
    cycle(1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    chk64("R8 key hold", keyOut, k);
    chk5("R8 round hold", roundOut, r);
  endtask

  task automatic testPriority();
    cycle(1'b1, 1'b1, 64'hA5A5_5A5A_0F0F_F0F0);
    chk64("R7 key", keyOut, 64'hA5A5_5A5A_0F0F_F0F0);
    chk5("R7 round", roundOut, 5'd1);
  endtask

  task automatic testWrap();
    logic [63:0] exp = 64'hFEDC_BA98_7654_3210;
    cycle(1'b1, 1'b0, exp);
    for (int i = 1; i <= 32; i++) begin
      exp = model(exp, 5'(i));
      cycle(1'b0, 1'b1, 64'h0);
      if (i == 31) chk5("R6 wrap to 0", roundOut, 5'd0);
    end
    chk5("R6 wrap back", roundOut, 5'd1);
    chk64("R4 key after wrap", keyOut, exp);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testZeroKey();
        testCancel();
        testChain();
        testIdle();
        testPriority();
        testWrap();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule